// File: doc/BRIEF.md
# Generalised Reverse Lookup Unit

This block is a purely combinational 64-bit permutation and logic unit. It starts from a seed word, which is either a supplied source value or, when the zero-source flag is raised, the constant 0x5555_5555_5555_5555. An optional invert then complements the seed. The seed passes through six butterfly rows with strides 1, 2, 4, 8, 16 and 32. Each row is enabled by one bit of a stage-enable amount. In an enabled row, every bit is recomputed by a 2-input lookup table that reads the two bits of its butterfly pair.

An 8-bit immediate holds two 4-entry tables. One table serves the bits that sit at the lower position of their pair, and the other serves the bits at the upper position. The same datapath can therefore act as a generalised bit reverse, as a generalised or-combine, or as a generator for many regular constant patterns from a single control word. The unit is meant to sit in an execution pipeline stage, fed directly by operand and immediate fields.

Top module: `grl_unit`

## Requirements
- R1: When `src_zero` is 1 the seed is 0x5555_5555_5555_5555 and `src_val` has no effect; when it is 0 the seed is `src_val`.
- R2: When `inv` is 1 the seed is bitwise complemented, so a zero source with invert gives 0xAAAA_AAAA_AAAA_AAAA.
- R3: With amount bits [5:0] all zero, `result` equals the seed.
- R4: Row k (stride 2^k, k = 0..5) is applied only when amount bit k is 1, and rows are applied in ascending stride order.
- R5: In a row of stride s, bit j and bit j^s form a pair. The lookup index is 2 bits wide. Index bit 1 is the pair member whose index has bit s clear, and index bit 0 is the member whose index has bit s set. The new bit j is the table entry at that index, counted LSB first.
- R6: Bits whose index has the stride bit clear use `imm[3:0]` as their table; bits whose index has it set use `imm[7:4]`.
- R7: With `imm` = 0xCA the unit equals a generalised reverse of the seed by amount[5:0].
- R8: With `imm` = 0xEE the unit equals a generalised or-combine of the seed by amount[5:0].
- R9: With zero source, invert 0 and `imm` = 0x6C, amounts 0x02, 0x06 and 0x0E give 0x1111_1111_1111_1111, 0x0101_0101_0101_0101 and 0x0001_0001_0001_0001.
- R10: With zero source, invert 1 and `imm` = 0xC6, amounts 0x02, 0x06 and 0x0E give 0x8888_8888_8888_8888, 0x8080_8080_8080_8080 and 0x8000_8000_8000_8000.
- R11: Amount bits [7:6] have no effect on `result`.
- R12: With `imm` = 0xAC every row passes its input unchanged, so `result` equals the seed for any amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_val | input | 64 | Source word used as the seed when not zero-selected |
| src_zero | input | 1 | Selects the constant 0x5555… seed |
| amount | input | 8 | Row enables; only bits [5:0] are used |
| imm | input | 8 | Two 4-entry tables: [3:0] for lower-position bits, [7:4] for upper-position bits |
| inv | input | 1 | Complements the seed |
| result | output | 64 | Output of the last row |

## Verification
The bound checker watches four behaviours at every input change. With no row enabled, or with the identity immediate, the output equals the seed. The reverse immediate preserves the population count. The or-combine immediate never clears a seed bit. The all-zero immediate clears the word whenever any row is enabled. Only the bench's scenarios can show the exact values: the documented constant patterns, agreement with a reverse and or-combine equation model, the ascending order of the rows, and the fact that the upper amount bits are ignored. Those need reference words that a single-cycle property cannot hold.

// File: rtl/grl_pkg.sv
package grl_pkg;
    localparam int unsigned GRL_XLEN  = 64;
    localparam int unsigned GRL_AMT_W = 8;
    localparam int unsigned GRL_IMM_W = 8;
endpackage

// File: rtl/grl_seed.sv
module grl_seed #(
    parameter int unsigned XLEN = grl_pkg::GRL_XLEN
) (
    input  logic [XLEN-1:0] src_val,
    input  logic            src_zero,
    input  logic            inv,
    output logic [XLEN-1:0] seed
);
    localparam logic [XLEN-1:0] ALT_ONES = {(XLEN/2){2'b01}};

    always_comb begin
        seed = src_zero ? ALT_ONES : src_val;
        if (inv) seed = ~seed;
    end
endmodule

// File: rtl/grl_row.sv
module grl_row #(
    parameter int unsigned XLEN = grl_pkg::GRL_XLEN,
    parameter int unsigned STEP = 1
) (
    input  logic [XLEN-1:0] x,
    input  logic            en,
    input  logic [7:0]      imm,
    output logic [XLEN-1:0] y
);
    for (genvar j = 0; j < XLEN; j++) begin : g_bit
        localparam int unsigned MATE  = j ^ STEP;
        localparam bit          UPPER = (j & STEP) != 0;
        logic       lo_b, hi_b;
        logic [3:0] tbl;
        if (UPPER) begin : g_up
            assign lo_b = x[MATE];
            assign hi_b = x[j];
            assign tbl  = imm[7:4];
        end else begin : g_lo
            assign lo_b = x[j];
            assign hi_b = x[MATE];
            assign tbl  = imm[3:0];
        end
        assign y[j] = en ? tbl[{lo_b, hi_b}] : x[j];
    end
endmodule

// File: rtl/grl_unit.sv
module grl_unit #(
    parameter int unsigned XLEN  = grl_pkg::GRL_XLEN,
    parameter int unsigned AMT_W = grl_pkg::GRL_AMT_W
) (
    input  logic [XLEN-1:0]  src_val,
    input  logic             src_zero,
    input  logic [AMT_W-1:0] amount,
    input  logic [7:0]       imm,
    input  logic             inv,
    output logic [XLEN-1:0]  result
);
    localparam int unsigned STAGES = $clog2(XLEN);

    logic [XLEN-1:0] seed_w;
    logic [XLEN-1:0] row_v [STAGES+1];
    logic            unused_amt_hi;

    assign unused_amt_hi = ^amount[AMT_W-1:STAGES];

    grl_seed #(.XLEN(XLEN)) u_seed (
        .src_val  (src_val),
        .src_zero (src_zero),
        .inv      (inv),
        .seed     (seed_w)
    );

    assign row_v[0] = seed_w;

    for (genvar k = 0; k < STAGES; k++) begin : g_row
        grl_row #(.XLEN(XLEN), .STEP(1 << k)) u_row (
            .x   (row_v[k]),
            .en  (amount[k]),
            .imm (imm),
            .y   (row_v[k+1])
        );
    end

    assign result = row_v[STAGES];
endmodule

// File: rtl/grl_unit_chk.sv
module grl_unit_chk #(
    parameter int unsigned XLEN  = grl_pkg::GRL_XLEN,
    parameter int unsigned AMT_W = grl_pkg::GRL_AMT_W
) (
    input logic [XLEN-1:0]  seed,
    input logic [AMT_W-1:0] amount,
    input logic [7:0]       imm,
    input logic [XLEN-1:0]  result
);
    localparam int unsigned STAGES = $clog2(XLEN);

    always_comb begin
        AST_IDLE_PASS: assert ((amount[STAGES-1:0] != '0) || (result == seed))
            else $error("idle rows changed the seed"); // R3
        AST_IDENT_TABLE: assert ((imm != 8'hAC) || (result == seed))
            else $error("identity tables changed the seed"); // R12
        AST_REV_POPCOUNT: assert ((imm != 8'hCA) || ($countones(result) == $countones(seed)))
            else $error("reverse changed the population count"); // R7
        AST_ORC_KEEPS_ONES: assert ((imm != 8'hEE) || ((seed & ~result) == '0))
            else $error("or-combine cleared a bit"); // R8
        AST_ZERO_TABLE: assert ((imm != 8'h00) || (amount[STAGES-1:0] == '0) || (result == '0))
            else $error("zero tables left bits set"); // R5
    end
endmodule

bind grl_unit grl_unit_chk #(.XLEN(XLEN), .AMT_W(AMT_W)) u_chk (
    .seed   (seed_w),
    .amount (amount),
    .imm    (imm),
    .result (result)
);

// File: tb/tb_grl_unit.sv
module tb_grl_unit;
    localparam int XLEN = 64;
    localparam int NV   = 9;
    // vector: src(64) zero(1) amount(8) imm(8) inv(1) expected(64)
    localparam logic [145:0] VEC [NV] = '{
        {64'h0, 1'b1, 8'h02, 8'h6C, 1'b0, 64'h1111_1111_1111_1111},
        {64'h0, 1'b1, 8'h06, 8'h6C, 1'b0, 64'h0101_0101_0101_0101},
        {64'h0, 1'b1, 8'h0E, 8'h6C, 1'b0, 64'h0001_0001_0001_0001},
        {64'h0, 1'b1, 8'h02, 8'hC6, 1'b1, 64'h8888_8888_8888_8888},
        {64'h0, 1'b1, 8'h06, 8'hC6, 1'b1, 64'h8080_8080_8080_8080},
        {64'h0, 1'b1, 8'h0E, 8'hC6, 1'b1, 64'h8000_8000_8000_8000},
        {64'h0123_4567_89AB_CDEF, 1'b0, 8'h00, 8'h00, 1'b0, 64'h0123_4567_89AB_CDEF},
        {64'h0123_4567_89AB_CDEF, 1'b0, 8'h00, 8'h00, 1'b1, 64'hFEDC_BA98_7654_3210},
        {64'h0123_4567_89AB_CDEF, 1'b0, 8'h3F, 8'hCA, 1'b0, 64'hF7B3_D591_E6A2_C480}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [XLEN-1:0] src_val = '0;
    logic            src_zero = 1'b0;
    logic [7:0]      amount = '0;
    logic [7:0]      imm = '0;
    logic            inv = 1'b0;
    logic [XLEN-1:0] result;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    grl_unit dut (.src_val(src_val), .src_zero(src_zero), .amount(amount),
                  .imm(imm), .inv(inv), .result(result));

    function automatic logic [XLEN-1:0] model(input logic [XLEN-1:0] s, input bit z,
            input logic [7:0] a, input logic [7:0] t, input bit iv);
        logic [XLEN-1:0] w, nw;
        w = z ? {32{2'b01}} : s;
        if (iv) w = ~w;
        for (int k = 0; k < 6; k++) begin
            if (a[k]) begin
                int st = 1 << k;
                nw = w;
                for (int j = 0; j < XLEN; j++) begin
                    if ((j & st) == 0) begin
                        nw[j]      = t[{w[j], w[j+st]}];
                        nw[j + st] = t[4 + {w[j], w[j+st]}];
                    end
                end
                w = nw;
            end
        end
        return w;
    endfunction

    function automatic logic [XLEN-1:0] swap_ref(input logic [XLEN-1:0] x,
            input logic [5:0] a, input bit orc);
        logic [XLEN-1:0] m, sw;
        for (int k = 0; k < 6; k++) begin
            if (a[k]) begin
                int st = 1 << k;
                for (int j = 0; j < XLEN; j++) m[j] = ((j & st) == 0);
                sw = ((x & m) << st) | ((x & ~m) >> st);
                x = orc ? (x | sw) : sw;
            end
        end
        return x;
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] exp);
        #1;
        n_chk++;
        if (result !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, result, exp);
        end
    endtask

    task automatic drive(input logic [XLEN-1:0] s, input bit z, input logic [7:0] a,
            input logic [7:0] t, input bit iv);
        @(negedge clk);
        src_val = s; src_zero = z; amount = a; imm = t; inv = iv;
    endtask

    initial begin
        logic [XLEN-1:0] r, base;
        // all-zero inputs: result zero, no rows enabled (R3)
        drive('0, 0, 8'h00, 8'h00, 0); check("R3", '0);
        // table walk: R9, R10 constants, R3/R2 pass-through, R7 full reverse
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][145:82], VEC[i][81], VEC[i][80:73], VEC[i][72:65], VEC[i][64]);
            check(i < 3 ? "R9" : (i < 6 ? "R10" : (i < 8 ? "R2_R3" : "R7")), VEC[i][63:0]);
        end
        // R1: zero source ignores src_val
        drive(64'hDEAD_BEEF_0BAD_F00D, 1, 8'h00, 8'h00, 0); check("R1", 64'h5555_5555_5555_5555);
        drive(64'hDEAD_BEEF_0BAD_F00D, 1, 8'h00, 8'h00, 1); check("R2", 64'hAAAA_AAAA_AAAA_AAAA);
        // R6: low table only on stride 1, own-bit tables: lower->0, upper->1
        drive(64'h0, 0, 8'h01, 8'hF0, 0); check("R6", {32{2'b10}});
        // R5: index order; low table 0x2 selects lower=0,upper=1 -> bit 1 only
        drive(64'h2, 0, 8'h01, 8'h02, 0); check("R5", 64'h1);
        // R4: order matters; stride1 then stride2 with asymmetric table
        drive(64'h1, 0, 8'h03, 8'h6C, 0); check("R4", model(64'h1, 0, 8'h03, 8'h6C, 0));
        // R11: upper amount bits ignored
        base = 64'h0F1E_2D3C_4B5A_6978;
        drive(base, 0, 8'h15, 8'h6C, 0); r = model(base, 0, 8'h15, 8'h6C, 0); check("R11", r);
        drive(base, 0, 8'hD5, 8'h6C, 0); check("R11", r);
        // R12: identity tables
        drive(base, 0, 8'h3F, 8'hAC, 1); check("R12", ~base);
        // random sweeps: model (R4,R5,R6), reverse (R7), or-combine (R8)
        for (int n = 0; n < 40; n++) begin
            logic [XLEN-1:0] s;
            logic [7:0] a, t;
            bit iv;
            s = {$urandom, $urandom}; a = 8'($urandom); t = 8'($urandom); iv = 1'($urandom);
            drive(s, 0, a, t, iv); check("R4_R5_R6", model(s, 0, a, t, iv));
            drive(s, 0, a, 8'hCA, 0); check("R7", swap_ref(s, a[5:0], 0));
            drive(s, 0, a, 8'hEE, 0); check("R8", swap_ref(s, a[5:0], 1));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule